// File: doc/BRIEF.md
# LIN Bus Remote Wake-up Filter

This block sits beside the mode controller of a LIN transceiver and watches the receive level while the node is in a low-power state (silent or sleep). The level it sees is already digitised and synchronised to the block clock. A remote wake-up is accepted only when three things happen in order. First the bus goes dominant. Then it stays dominant without a break for at least a filter time, measured in microsecond ticks. Then it returns to recessive. On the cycle after that closing rising edge the block raises a single-cycle wake request.

A dominant level that is already present when the block is armed counts as the start of a dominant phase. This means a bus-to-ground short that is released during a low-power mode still ends in a wake-up. A dominant burst shorter than the filter time restarts the sequence without a request. The block also raises a sticky pre-wake flag as soon as a dominant level is seen while armed. This flag switches on the receiver and the slave termination. Dropping the armed input clears everything.

Top module: `lin_wake_filter`

## Requirements
- R1: During and directly after reset, `wake_req_o` and `prewake_o` are 0.
- R2: While `arm_i` is 0, both outputs are 0 one cycle later. A dominant phase that is interrupted by disarming does not produce a request after re-arming with the bus recessive.
- R3: The encoding of `bus_rx_i` is 0 for dominant and 1 for recessive. The sequence must be: dominant, then at least FILT_US ticks of `us_tick_i` sampled high while dominant, then recessive. In the clock cycle after the first recessive sample, `wake_req_o` is 1.
- R4: No request is raised when the filter time expires while the bus stays dominant. The request waits for the rising edge.
- R5: A return to recessive after fewer than FILT_US ticks gives no request and restarts detection. A following complete sequence is still accepted.
- R6: Exactly FILT_US ticks qualify the dominant phase, and FILT_US-1 ticks do not.
- R7: If the bus is already dominant when `arm_i` rises, the dominant phase is counted from arming, and its release after enough ticks raises a request.
- R8: `prewake_o` goes to 1 in the cycle after the first dominant sample while armed. It stays at 1 until `arm_i` is 0, regardless of later bus levels.
- R9: The tick counter saturates at FILT_US. A dominant phase lasting many more ticks than the counter range still produces exactly one request on release.
- R10: `wake_req_o` is high for exactly one cycle per accepted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Low-power mode active; enables detection |
| bus_rx_i | input | 1 | Synchronised bus level, 0 = dominant |
| us_tick_i | input | 1 | One-cycle microsecond time base |
| wake_req_o | output | 1 | One-cycle remote wake-up request |
| prewake_o | output | 1 | Enables receiver and termination |

## Verification
Every result the block produces is due one clock after the input sample that causes it. The wake request follows the first recessive sample of a qualified phase by one cycle, and the pre-wake flag follows the first dominant sample by one cycle. The bench drives inputs on the falling edge. Its behavioural model updates on the rising edge from the same samples, and both outputs are compared on the next falling edge, so each expectation lands in exactly the cycle it is due. Directed scenarios also count request pulses. These counts cover the exact-threshold, short-glitch, dominant-at-arming and saturated-counter cases.

// File: rtl/lin_wk_pkg.sv
package lin_wk_pkg;
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_DOM  = 2'd1,
    WK_QUAL = 2'd2
  } wk_state_e;
endpackage

// File: rtl/lin_wk_timer.sv
module lin_wk_timer #(
  parameter int LIMIT = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done_o = (cnt_q >= LIM);

  always_comb begin
    cnt_en = clr_i | (step_i & ~done_o);
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R9
  AST_CNT_HOLD_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !clr_i) |=> done_o); // R9
endmodule

// File: rtl/lin_wk_prewake.sv
module lin_wk_prewake (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic bus_rx_i,
  output logic prewake_o
);
  logic pw_q;
  logic pw_d;

  always_comb begin
    if (!arm_i) begin
      pw_d = 1'b0;
    end else begin
      pw_d = pw_q | ~bus_rx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q <= 1'b0;
    end else begin
      pw_q <= pw_d;
    end
  end

  assign prewake_o = pw_q;

  AST_PREWAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (prewake_o && arm_i) |=> prewake_o); // R8
  AST_PREWAKE_ON_DOM: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !bus_rx_i) |=> prewake_o); // R8
endmodule

// File: rtl/lin_wk_fsm.sv
module lin_wk_fsm
  import lin_wk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic bus_rx_i,
  input  logic tick_i,
  input  logic tmr_done_i,
  output logic tmr_clr_o,
  output logic tmr_step_o,
  output logic wake_o
);
  wk_state_e st_q;
  wk_state_e st_d;
  logic      wake_q;
  logic      wake_d;

  always_comb begin
    st_d   = st_q;
    wake_d = 1'b0;
    if (!arm_i) begin
      st_d = WK_IDLE;
    end else begin
      case (st_q)
        WK_IDLE: begin
          if (!bus_rx_i) st_d = WK_DOM;
        end
        WK_DOM: begin
          if (bus_rx_i) begin
            st_d   = WK_IDLE;
            wake_d = tmr_done_i;
          end else if (tmr_done_i) begin
            st_d = WK_QUAL;
          end
        end
        WK_QUAL: begin
          if (bus_rx_i) begin
            st_d   = WK_IDLE;
            wake_d = 1'b1;
          end
        end
        default: st_d = WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_q <= wake_d;
    end
  end

  assign tmr_clr_o  = ~arm_i | (st_q == WK_IDLE);
  assign tmr_step_o = arm_i & (st_q == WK_DOM) & ~bus_rx_i & tick_i;
  assign wake_o     = wake_q;

  AST_QUAL_NEEDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WK_QUAL) |-> tmr_done_i); // R6
  AST_NO_WAKE_WHILE_DOM: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !bus_rx_i) |=> !wake_q); // R4
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
  parameter int FILT_US = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic bus_rx_i,
  input  logic us_tick_i,
  output logic wake_req_o,
  output logic prewake_o
);
  logic tmr_clr;
  logic tmr_step;
  logic tmr_done;

  lin_wk_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .bus_rx_i   (bus_rx_i),
    .tick_i     (us_tick_i),
    .tmr_done_i (tmr_done),
    .tmr_clr_o  (tmr_clr),
    .tmr_step_o (tmr_step),
    .wake_o     (wake_req_o)
  );

  lin_wk_timer #(.LIMIT(FILT_US)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tmr_clr),
    .step_i (tmr_step),
    .done_o (tmr_done)
  );

  lin_wk_prewake u_pw (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_i),
    .bus_rx_i  (bus_rx_i),
    .prewake_o (prewake_o)
  );

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |=> !wake_req_o); // R10
  AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req_o) |-> ($past(bus_rx_i) && $past(arm_i))); // R3
  AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> (!wake_req_o && !prewake_o)); // R2
endmodule

// File: tb/sim_lin_wake_filter.sv
module sim_lin_wake_filter;
  localparam int F = 5;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  logic rst_n, arm, bus, tick;
  logic wake, pw;
  int   checks = 0;
  int   errors = 0;
  int   wakes  = 0;
  string cur_req = "R1";

  // reference model state
  bit   m_active;
  int   m_ticks;
  bit   m_wake;
  bit   m_pw;

  always #(CLK_P/2) clk = ~clk;

  lin_wake_filter #(.FILT_US(F)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .bus_rx_i(bus),
    .us_tick_i(tick), .wake_req_o(wake), .prewake_o(pw)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_ticks = 0; m_wake = 0; m_pw = 0;
    end else if (!arm) begin
      m_active = 0; m_ticks = 0; m_wake = 0; m_pw = 0;
    end else begin
      m_wake = 0;
      if (!bus) m_pw = 1;
      if (bus) begin
        if (m_active && m_ticks >= F) m_wake = 1;
        m_active = 0; m_ticks = 0;
      end else if (!m_active) begin
        m_active = 1; m_ticks = 0;
      end else if (tick && m_ticks < F) begin
        m_ticks++;
      end
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check(cur_req, wake, m_wake, "wake_req_o");
    check(cur_req, pw, m_pw, "prewake_o");
    if (wake === 1'b1) wakes++;
  end

  task automatic cyc(logic b, logic t);
    @(negedge clk);
    bus = b; tick = t;
  endtask

  // enter dominant, then n ticks, then one idle dominant cycle
  task automatic dom_run(int n);
    cyc(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b0);
      cyc(1'b0, 1'b1);
    end
    cyc(1'b0, 1'b0);
  endtask

  task automatic rec_run(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
  endtask

  task automatic expect_wakes(string req, int base, int exp);
    checks++;
    if (wakes - base != exp) begin
      errors++;
      $display("FAIL %s wake count: actual %0d expected %0d", req, wakes - base, exp);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; arm = 1'b0; bus = 1'b1; tick = 1'b0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check("R1", wake, 1'b0, "wake in reset");
    check("R1", pw, 1'b0, "prewake in reset");
    rst_n = 1'b1;
    rec_run(2);

    // R3 R10: full sequence
    cur_req = "R3"; @(negedge clk); arm = 1'b1; bus = 1'b1;
    rec_run(2); base = wakes;
    dom_run(F + 2); rec_run(4);
    expect_wakes("R3", base, 1);
    cur_req = "R10";
    expect_wakes("R10", base, 1);

    // R4: hold dominant long, no wake until release
    cur_req = "R4"; base = wakes;
    dom_run(F + 6);
    expect_wakes("R4", base, 0);
    rec_run(3);
    expect_wakes("R4", base, 1);

    // R6: exact threshold
    cur_req = "R6"; base = wakes;
    dom_run(F - 1); rec_run(3);
    expect_wakes("R6", base, 0);
    dom_run(F); rec_run(3);
    expect_wakes("R6", base, 1);

    // R5: glitch then full sequence
    cur_req = "R5"; base = wakes;
    dom_run(2); rec_run(1); dom_run(2); rec_run(2);
    expect_wakes("R5", base, 0);
    dom_run(F); rec_run(3);
    expect_wakes("R5", base, 1);

    // R2: disarm mid-phase, rearm recessive
    cur_req = "R2"; base = wakes;
    dom_run(F + 1);
    @(negedge clk); arm = 1'b0;
    rec_run(2);
    check("R2", pw, 1'b0, "prewake after disarm");
    @(negedge clk); arm = 1'b1;
    rec_run(4);
    expect_wakes("R2", base, 0);

    // R7: dominant already present at arming (released short)
    cur_req = "R7"; base = wakes;
    @(negedge clk); arm = 1'b0;
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b1);
    @(negedge clk); arm = 1'b1;
    for (int i = 0; i < F; i++) begin cyc(1'b0, 1'b0); cyc(1'b0, 1'b1); end
    cyc(1'b0, 1'b0); rec_run(3);
    expect_wakes("R7", base, 1);

    // R8: prewake sticky across recessive
    cur_req = "R8";
    @(negedge clk); arm = 1'b0; rec_run(2);
    @(negedge clk); arm = 1'b1; rec_run(2);
    check("R8", pw, 1'b0, "prewake before dominant");
    cyc(1'b0, 1'b0); cyc(1'b1, 1'b0);
    check("R8", pw, 1'b1, "prewake after dominant");
    rec_run(5);
    check("R8", pw, 1'b1, "prewake held");

    // R9: very long dominant
    cur_req = "R9"; base = wakes;
    dom_run(40); rec_run(3);
    expect_wakes("R9", base, 1);

    @(negedge clk); arm = 1'b0; rec_run(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule